// File: doc/BRIEF.md
# Dual-Limit Watchdog Comparator

This block tests one captured signed sample against two programmable limits and raises a sticky watchdog interrupt when a limit condition is met. Each limit has its own magnitude, sign and trip direction. A trip direction of "above" fires when the sample is strictly greater than the limit. A trip direction of "below" fires when the sample is strictly less than it. The sample is held in a register when it is accepted. It is checked against limit 1 in the next cycle and against limit 2 in the cycle after that, and a one-cycle done strobe follows.

The limits are loaded through two register-write ports and can be read back as 16-bit words. The enable input carries the watchdog-enable bit of the active instruction word (bit 11 of that word). A sample that arrives with the enable low is not compared at all. Two status outputs record which limit tripped. The interrupt output is their OR. Both status bits stay set until the clear input or reset.

Top module: `dual_limit_watchdog`

## Requirements
- R1: A limit register holds three fields: bits 7:0 are the magnitude, bit 8 is the sign, and bit 9 is the direction. Its 16-bit read value shows these bits, and bits 15:10 are always 0. Reset loads all fields with 0.
- R2: With direction 1, a limit trips when the sample, read as 9-bit two's complement, is strictly greater than the limit value {sign, magnitude}, also read as 9-bit two's complement.
- R3: With direction 0, a limit trips when the sample is strictly less than the limit value.
- R4: A sample equal to the limit value trips in neither direction.
- R5: Take the clock edge at which a sample is accepted. The limit 1 result shows on `hit1` after the next edge. The limit 2 result shows on `hit2` one edge later. Both comparisons use the sample that was captured on acceptance.
- R6: `done` is high for exactly one cycle. It rises on the same edge on which the limit 2 result appears.
- R7: A sample is accepted only when `wd_en` is 1 at the edge where `smp_valid` is high. If the sample is not accepted, no flag changes and `done` stays low.
- R8: `hit1` and `hit2` are sticky, and `irq` equals `hit1 | hit2`. `clr` clears both bits. If a trip and `clr` occur in the same cycle, the trip wins.
- R9: A `smp_valid` pulse that arrives while a comparison is still in progress is ignored.
- R10: After reset, `hit1`, `hit2`, `irq` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lim1_we | input | 1 | Write strobe for limit 1 |
| lim1_wdata | input | 10 | Limit 1 write data: {direction, sign, magnitude} |
| lim1_rdata | output | 16 | Limit 1 read value, with bits 15:10 held at zero |
| lim2_we | input | 1 | Write strobe for limit 2 |
| lim2_wdata | input | 10 | Limit 2 write data: {direction, sign, magnitude} |
| lim2_rdata | output | 16 | Limit 2 read value, with bits 15:10 held at zero |
| wd_en | input | 1 | Watchdog-enable bit of the active instruction |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 9 | Signed sample, two's complement |
| clr | input | 1 | Clears both trip bits |
| hit1 | output | 1 | Sticky: limit 1 tripped |
| hit2 | output | 1 | Sticky: limit 2 tripped |
| irq | output | 1 | Watchdog interrupt |
| done | output | 1 | One-cycle strobe when both comparisons are complete |

## Verification
The assertions assume that the limit registers are not rewritten while a comparison is in progress, so that each trip decision follows from stable limit values. They also assume that `clr` and `smp_valid` are driven synchronously and never carry X after reset. The stimulus writes limits only between sample runs and drives every input at the falling clock edge. Busy-time `smp_valid` pulses appear only in a directed case, and that case carries a different sample value so that a wrongly accepted capture would show up.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int MAG_W = 8;
  localparam int VAL_W = MAG_W + 1;

  typedef struct packed {
    logic             dir;
    logic             sgn;
    logic [MAG_W-1:0] mag;
  } wd_limit_t;

  localparam int FIELD_W = $bits(wd_limit_t);

  // Signed compare of the sample against one limit; equality never trips.
  function automatic logic limit_hit(input logic [VAL_W-1:0] smp, input wd_limit_t lim);
    logic signed [VAL_W-1:0] s;
    logic signed [VAL_W-1:0] l;
    s = $signed(smp);
    l = $signed({lim.sgn, lim.mag});
    return lim.dir ? (s > l) : (s < l);
  endfunction
endpackage

// File: rtl/wdc_limit_reg.sv
module wdc_limit_reg
  import wdc_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [FIELD_W-1:0] wdata,
  output logic [REG_W-1:0]   rdata,
  output wd_limit_t          lim
);
  localparam int PAD_W = REG_W - FIELD_W;

  logic [FIELD_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  assign lim   = wd_limit_t'(q);
  assign rdata = {{PAD_W{1'b0}}, q};

  // R1: the write port lands in the register on the next edge
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));
endmodule

// File: rtl/wdc_compare_seq.sv
module wdc_compare_seq
  import wdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_en,
  input  logic             smp_valid,
  input  logic [VAL_W-1:0] smp_data,
  input  wd_limit_t        lim1,
  input  wd_limit_t        lim2,
  input  logic             clr,
  output logic             hit1,
  output logic             hit2,
  output logic             done
);
  logic             ph1, ph2;
  logic [VAL_W-1:0] samp_q;
  logic             busy, accept, hit_now1, hit_now2;

  assign busy     = ph1 | ph2;
  assign accept   = smp_valid & wd_en & ~busy;
  assign hit_now1 = ph1 & limit_hit(samp_q, lim1);
  assign hit_now2 = ph2 & limit_hit(samp_q, lim2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph1    <= 1'b0;
      ph2    <= 1'b0;
      done   <= 1'b0;
      samp_q <= '0;
    end else begin
      ph1  <= accept;
      ph2  <= ph1;
      done <= ph2;
      if (accept) samp_q <= smp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit1 <= 1'b0;
      hit2 <= 1'b0;
    end else begin
      if (hit_now1) hit1 <= 1'b1;
      else if (clr) hit1 <= 1'b0;
      if (hit_now2) hit2 <= 1'b1;
      else if (clr) hit2 <= 1'b0;
    end
  end

  a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
    ph1 |=> ph2);
  a_r6_done_after_second: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |=> done);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !wd_en && !busy) |=> !ph1);
  a_r8_sticky1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && !clr) |=> hit1);
  a_r8_sticky2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit2 && !clr) |=> hit2);
  a_r8_clear1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit_now1) |=> !hit1);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now2 |=> hit2);
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(samp_q));
endmodule

// File: rtl/dual_limit_watchdog.sv
module dual_limit_watchdog
  import wdc_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lim1_we,
  input  logic [FIELD_W-1:0] lim1_wdata,
  output logic [REG_W-1:0]   lim1_rdata,
  input  logic               lim2_we,
  input  logic [FIELD_W-1:0] lim2_wdata,
  output logic [REG_W-1:0]   lim2_rdata,
  input  logic               wd_en,
  input  logic               smp_valid,
  input  logic [VAL_W-1:0]   smp_data,
  input  logic               clr,
  output logic               hit1,
  output logic               hit2,
  output logic               irq,
  output logic               done
);
  localparam int N_LIM = 2;

  logic [N_LIM-1:0]               we_v;
  logic [N_LIM-1:0][FIELD_W-1:0]  wd_v;
  logic [N_LIM-1:0][REG_W-1:0]    rd_v;
  wd_limit_t                      lim_v [N_LIM];

  assign we_v = {lim2_we, lim1_we};
  assign wd_v = {lim2_wdata, lim1_wdata};

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    wdc_limit_reg #(.REG_W(REG_W)) i_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_v[g]),
      .wdata (wd_v[g]),
      .rdata (rd_v[g]),
      .lim   (lim_v[g])
    );
  end

  assign lim1_rdata = rd_v[0];
  assign lim2_rdata = rd_v[1];

  wdc_compare_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wd_en     (wd_en),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .lim1      (lim_v[0]),
    .lim2      (lim_v[1]),
    .clr       (clr),
    .hit1      (hit1),
    .hit2      (hit2),
    .done      (done)
  );

  assign irq = hit1 | hit2;

  // R10: after reset nothing is pending
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq && !done));
endmodule

// File: tb/test_dual_limit_watchdog.sv
module test_dual_limit_watchdog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lim1_we = 1'b0, lim2_we = 1'b0;
  logic [9:0] lim1_wdata = '0, lim2_wdata = '0;
  logic [15:0] lim1_rdata, lim2_rdata;
  logic wd_en = 1'b0, smp_valid = 1'b0, clr = 1'b0;
  logic [8:0] smp_data = '0;
  logic hit1, hit2, irq, done;

  int checks = 0;
  int errors = 0;
  logic e1 = 1'b0, e2 = 1'b0;
  logic [9:0] l1 = '0, l2 = '0;

  always #2.5 clk = ~clk;

  dual_limit_watchdog i_dual_limit_watchdog (
    .clk(clk), .rst_n(rst_n),
    .lim1_we(lim1_we), .lim1_wdata(lim1_wdata), .lim1_rdata(lim1_rdata),
    .lim2_we(lim2_we), .lim2_wdata(lim2_wdata), .lim2_rdata(lim2_rdata),
    .wd_en(wd_en), .smp_valid(smp_valid), .smp_data(smp_data), .clr(clr),
    .hit1(hit1), .hit2(hit2), .irq(irq), .done(done)
  );

  function automatic int as_int(input logic [8:0] v);
    return v[8] ? int'(v) - 512 : int'(v);
  endfunction

  function automatic logic ref_trip(input logic [8:0] s, input logic [9:0] r);
    int si = as_int(s);
    int li = as_int(r[8:0]);
    if (r[9]) return si > li;
    return si < li;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_limits(input logic [9:0] a, input logic [9:0] b);
    lim1_wdata = a; lim2_wdata = b; lim1_we = 1'b1; lim2_we = 1'b1;
    @(negedge clk);
    lim1_we = 1'b0; lim2_we = 1'b0;
    l1 = a; l2 = b;
    chk("R1 lim1 readback", {16'h0, lim1_rdata}, {22'h0, a});
    chk("R1 lim2 readback", {16'h0, lim2_rdata}, {22'h0, b});
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    e1 = 1'b0; e2 = 1'b0;
    chk("R8 clear", {hit1, hit2, irq}, 3'b000);
  endtask

  // one sample run; busy_junk pulses valid while busy, clr_mid clears during limit 1 compare
  task automatic run(input logic [8:0] s, input logic en, input logic busy_junk,
                     input logic clr_mid, input string tag);
    logic t1, t2;
    t1 = en & ref_trip(s, l1);
    t2 = en & ref_trip(s, l2);
    smp_data = s; wd_en = en; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = busy_junk; smp_data = ~s; clr = clr_mid;
    @(negedge clk);
    clr = 1'b0;
    if (clr_mid) begin e1 = 1'b0; e2 = 1'b0; end
    e1 = e1 | t1;
    chk({tag, " R5 hit1 after first compare"}, hit1, e1);
    chk({tag, " R5 hit2 not yet"}, hit2, e2);
    @(negedge clk);
    smp_valid = 1'b0;
    e2 = e2 | t2;
    chk({tag, " R5 hit2 after second compare"}, hit2, e2);
    chk({tag, " R6/R7 done"}, done, en);
    chk({tag, " R8 irq"}, irq, e1 | e2);
    @(negedge clk);
    chk({tag, " R6 done single cycle"}, done, 1'b0);
    chk({tag, " R9 no extra capture"}, {hit1, hit2}, {e1, e2});
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog timeout actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10 reset flags", {hit1, hit2, irq, done}, 4'b0);
    chk("R1 reset lim1", {16'h0, lim1_rdata}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 above, R3 below, R4 equality
    write_limits({1'b1, 9'd10}, {1'b0, 9'h1F6});      // >10 ; < -10
    run(9'd11, 1'b1, 1'b0, 1'b0, "R2 above");
    do_clear();
    run(9'd10, 1'b1, 1'b0, 1'b0, "R4 equal above");
    run(9'h1F6, 1'b1, 1'b0, 1'b0, "R4 equal below");
    run(9'h1F5, 1'b1, 1'b0, 1'b0, "R3 below");
    do_clear();
    write_limits({1'b1, 9'h100}, {1'b0, 9'h0FF});     // > -256 ; < 255
    run(9'h100, 1'b1, 1'b0, 1'b0, "R4 extremes equal");
    run(9'h000, 1'b1, 1'b0, 1'b0, "R2 R3 sign handling");
    do_clear();
    write_limits({1'b1, 9'd0}, {1'b1, 9'd0});
    run(9'd50, 1'b0, 1'b0, 1'b0, "R7 disabled");
    run(9'd50, 1'b1, 1'b1, 1'b0, "R9 busy pulses");
    run(9'd60, 1'b1, 1'b0, 1'b1, "R8 set beats clear");
    do_clear();

    for (int i = 0; i < 60; i++) begin
      logic [9:0] a, b;
      a = 10'($urandom); b = 10'($urandom);
      write_limits(a, b);
      if ($urandom_range(0, 2) == 0) do_clear();
      run(9'($urandom), ($urandom_range(0, 3) != 0), 1'b0, 1'b0, "rand R2 R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule